// File: doc/BRIEF.md
# Script Transfer-Control Execution Unit

This unit carries out the control-flow instructions of a small script processor: jump, call, return, a halting interrupt and a non-halting (on-the-fly) interrupt. It accepts one decoded instruction at a time over a valid/ready handshake. It evaluates the branch condition against the latched bus phase lines, the received data byte or the ALU carry flag. It then updates the instruction pointer, a single-level return-address register, the interrupt output and its status vector, and a sticky on-the-fly status bit. Every accepted instruction completes in the clock cycle that accepts it.

The instruction pointer always holds the sequential next address. A false condition leaves it alone. A taken jump or call loads the target operand, and a taken call first saves the pointer into the return register. A taken return reloads the pointer from that register without checking that a call came before. A taken halting interrupt drives the active-low interrupt line, copies the target operand into the status vector and stops the unit. Only a host write of the instruction pointer starts it again. A taken on-the-fly interrupt only sets a status bit, which the host clears by writing a one to that bit.

Top module: `xfer_ctl_unit`

## Requirements
- R1: After reset, ip equals RESET_IP (default 0), ret_addr and status_vec are 0, istat is 0, int_n is 1 and instr_ready is 1.
- R2: With instr_use_carry=1, the condition is true exactly when alu_carry equals instr_polarity. The phase and data enables are ignored in this mode.
- R3: With instr_use_carry=0 and instr_cmp_phase=1, the phase test passes when bus_phase equals the 3-bit expected phase instr_phase. A disabled phase test counts as passing.
- R4: With instr_use_carry=0 and instr_cmp_data=1, the data test passes when bus_data equals instr_cmp_word[7:0] on every bit whose mask bit in instr_cmp_word[15:8] is 0. A disabled data test counts as passing. The phase and data results are ANDed, and the condition is true when that AND equals instr_polarity.
- R5: When an accepted instruction's condition is false, ip, ret_addr, int_n, status_vec and istat keep their values.
- R6: A taken jump (instr_op=0) loads ip from instr_target on the accepting edge and leaves ret_addr unchanged.
- R7: A taken call (instr_op=1) stores the current ip into ret_addr and loads ip from instr_target on the same edge.
- R8: A taken return (instr_op=2) loads ip from ret_addr, whether or not a call has run. No interrupt or flag results.
- R9: A taken halting interrupt (instr_op=3) drives int_n low, loads status_vec from instr_target and deasserts instr_ready, leaving ip unchanged. Instructions presented while halted are ignored.
- R10: A host write (host_ip_wr=1) loads ip from host_ip_wdata and, if the unit was halted, returns int_n and instr_ready to 1.
- R11: A taken on-the-fly interrupt (instr_op=4) sets istat[2] without halting. The bit stays set through further events until a host write with host_istat_wr=1 and host_istat_wdata[2]=1. Writes with bit 2 at 0 leave it set.
- R12: Opcodes 5 to 7 change no output, whatever the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | A decoded instruction is presented |
| instr_ready | output | 1 | Unit accepts an instruction this cycle (low while halted) |
| instr_op | input | 3 | 0 jump, 1 call, 2 return, 3 interrupt, 4 on-the-fly interrupt |
| instr_use_carry | input | 1 | Condition tests the ALU carry instead of phase/data |
| instr_cmp_phase | input | 1 | Enable phase comparison |
| instr_cmp_data | input | 1 | Enable data comparison |
| instr_polarity | input | 1 | Condition is true when the test result equals this bit |
| instr_phase | input | PHASE_W | Expected bus phase |
| instr_cmp_word | input | 2*DATA_W | Low byte compare data, high byte mask (1 = ignore) |
| instr_target | input | ADDR_W | Branch target or interrupt vector |
| bus_phase | input | PHASE_W | Phase lines latched on the request strobe |
| bus_data | input | DATA_W | Received data byte |
| alu_carry | input | 1 | ALU carry flag |
| host_ip_wr | input | 1 | Host write of the instruction pointer (restarts) |
| host_ip_wdata | input | ADDR_W | Value written to the instruction pointer |
| host_istat_wr | input | 1 | Host write to the interrupt status register |
| host_istat_wdata | input | ISTAT_W | Write-one-to-clear data for the status register |
| ip | output | ADDR_W | Instruction pointer (sequential next address) |
| ret_addr | output | ADDR_W | Saved return address |
| int_n | output | 1 | Active-low halting interrupt |
| status_vec | output | ADDR_W | Vector copied from the interrupting instruction |
| istat | output | ISTAT_W | Interrupt status, bit 2 is the on-the-fly flag |

## Verification
The bench builds the unit with its defaults: a 3-bit phase, an 8-bit data byte with the mask variant enabled, and 32-bit addresses. The narrow phase field allows every expected-phase against bus-phase pairing under both polarities. A stepped sweep of data bytes against four mask patterns, with the phase test both matching and missing, covers the masked compare and the AND. Every opcode is also run with true and false conditions, including return before any call, instructions offered while halted, and clear writes with and without the on-the-fly bit.

// File: rtl/xfer_ctl_pkg.sv
package xfer_ctl_pkg;

   typedef enum logic [2:0] {
      OP_JUMP = 3'd0,
      OP_CALL = 3'd1,
      OP_RET  = 3'd2,
      OP_INT  = 3'd3,
      OP_FLY  = 3'd4
   } xfer_op_e;

   function automatic logic op_is(input logic [2:0] raw, input xfer_op_e kind);
      return raw == kind;
   endfunction

endpackage

// File: rtl/xfer_cond_eval.sv
module xfer_cond_eval #(
   parameter int PHASE_W  = 3,
   parameter int DATA_W   = 8,
   parameter bit HAS_MASK = 1'b1
) (
   input  logic                  use_carry,
   input  logic                  cmp_phase,
   input  logic                  cmp_data,
   input  logic                  polarity,
   input  logic [PHASE_W-1:0]    exp_phase,
   input  logic [2*DATA_W-1:0]   cmp_word,
   input  logic [PHASE_W-1:0]    bus_phase,
   input  logic [DATA_W-1:0]     bus_data,
   input  logic                  alu_carry,
   output logic                  cond_true
);

   localparam int MASK_LSB = DATA_W;

   logic [DATA_W-1:0] ref_byte;
   logic [DATA_W-1:0] ign_mask;
   logic [DATA_W-1:0] diff;
   logic              phase_ok;
   logic              data_ok;
   logic              raw_result;

   assign ref_byte = cmp_word[DATA_W-1:0];

   generate
      if (HAS_MASK) begin : g_mask
         assign ign_mask = cmp_word[MASK_LSB +: DATA_W];
      end else begin : g_nomask
         assign ign_mask = '0;
      end
   endgenerate

   assign diff = (bus_data ^ ref_byte) & ~ign_mask;

   always_comb begin
      phase_ok = !cmp_phase || (bus_phase == exp_phase);
      data_ok  = !cmp_data  || (diff == '0);
      if (use_carry) begin
         raw_result = alu_carry;
      end else begin
         raw_result = phase_ok && data_ok;
      end
      cond_true = (raw_result == polarity);
   end

endmodule

// File: rtl/xfer_ip_ctl.sv
module xfer_ip_ctl
   import xfer_ctl_pkg::*;
#(
   parameter int              ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              taken,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] target,
   input  logic              host_ip_wr,
   input  logic [ADDR_W-1:0] host_ip_wdata,
   output logic [ADDR_W-1:0] ip,
   output logic [ADDR_W-1:0] ret_addr
);

   logic              act;
   logic              is_jump;
   logic              is_call;
   logic              is_ret;
   logic [ADDR_W-1:0] ip_next;

   assign act     = fire && taken;
   assign is_jump = op_is(op, OP_JUMP);
   assign is_call = op_is(op, OP_CALL);
   assign is_ret  = op_is(op, OP_RET);

   always_comb begin
      ip_next = ip;
      if (host_ip_wr) begin
         ip_next = host_ip_wdata;
      end else if (act && (is_jump || is_call)) begin
         ip_next = target;
      end else if (act && is_ret) begin
         ip_next = ret_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ip <= RESET_IP;
      end else begin
         ip <= ip_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_addr <= '0;
      end else if (act && is_call) begin
         ret_addr <= ip;
      end
   end

   assert_call_saves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && taken && op == OP_CALL) |=> (ret_addr == $past(ip)));

   assert_ret_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && taken && op == OP_RET && !host_ip_wr) |=> (ip == $past(ret_addr)));

   assert_false_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !taken && !host_ip_wr) |=> ($stable(ip) && $stable(ret_addr)));

   assert_host_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_ip_wr |=> (ip == $past(host_ip_wdata)));

endmodule

// File: rtl/xfer_int_ctl.sv
module xfer_int_ctl
   import xfer_ctl_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ISTAT_W = 8,
   parameter int FLY_BIT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic               taken,
   input  logic [2:0]         op,
   input  logic [ADDR_W-1:0]  target,
   input  logic               host_ip_wr,
   input  logic               host_istat_wr,
   input  logic [ISTAT_W-1:0] host_istat_wdata,
   output logic               halted,
   output logic [ADDR_W-1:0]  status_vec,
   output logic [ISTAT_W-1:0] istat
);

   logic act_int;
   logic act_fly;
   logic fly_clr;
   logic fly_q;

   assign act_int = fire && taken && op_is(op, OP_INT);
   assign act_fly = fire && taken && op_is(op, OP_FLY);
   assign fly_clr = host_istat_wr && host_istat_wdata[FLY_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted <= 1'b0;
      end else if (host_ip_wr) begin
         halted <= 1'b0;
      end else if (act_int) begin
         halted <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_vec <= '0;
      end else if (act_int) begin
         status_vec <= target;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fly_q <= 1'b0;
      end else if (act_fly) begin
         fly_q <= 1'b1;
      end else if (fly_clr) begin
         fly_q <= 1'b0;
      end
   end

   generate
      for (genvar b = 0; b < ISTAT_W; b++) begin : g_istat
         if (b == FLY_BIT) begin : g_fly
            assign istat[b] = fly_q;
         end else begin : g_zero
            assign istat[b] = 1'b0;
         end
      end
   endgenerate

   assert_int_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && taken && op == OP_INT && !host_ip_wr) |=>
         (halted && status_vec == $past(target)));

   assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !host_ip_wr) |=> (halted && $stable(status_vec)));

   assert_fly_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (istat[FLY_BIT] && !(host_istat_wr && host_istat_wdata[FLY_BIT])) |=> istat[FLY_BIT]);

   assert_fly_no_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && taken && op == OP_FLY) |=> (istat[FLY_BIT] && !halted));

endmodule

// File: rtl/xfer_ctl_unit.sv
module xfer_ctl_unit
   import xfer_ctl_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                PHASE_W  = 3,
   parameter int                DATA_W   = 8,
   parameter int                ISTAT_W  = 8,
   parameter int                FLY_BIT  = 2,
   parameter bit                HAS_MASK = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  instr_valid,
   output logic                  instr_ready,
   input  logic [2:0]            instr_op,
   input  logic                  instr_use_carry,
   input  logic                  instr_cmp_phase,
   input  logic                  instr_cmp_data,
   input  logic                  instr_polarity,
   input  logic [PHASE_W-1:0]    instr_phase,
   input  logic [2*DATA_W-1:0]   instr_cmp_word,
   input  logic [ADDR_W-1:0]     instr_target,
   input  logic [PHASE_W-1:0]    bus_phase,
   input  logic [DATA_W-1:0]     bus_data,
   input  logic                  alu_carry,
   input  logic                  host_ip_wr,
   input  logic [ADDR_W-1:0]     host_ip_wdata,
   input  logic                  host_istat_wr,
   input  logic [ISTAT_W-1:0]    host_istat_wdata,
   output logic [ADDR_W-1:0]     ip,
   output logic [ADDR_W-1:0]     ret_addr,
   output logic                  int_n,
   output logic [ADDR_W-1:0]     status_vec,
   output logic [ISTAT_W-1:0]    istat
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("xfer_ctl_unit: ADDR_W must be at least 2");
      end
      if (PHASE_W < 1) begin : g_bad_phase
         $error("xfer_ctl_unit: PHASE_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("xfer_ctl_unit: DATA_W must be at least 1");
      end
      if (FLY_BIT >= ISTAT_W) begin : g_bad_fly
         $error("xfer_ctl_unit: FLY_BIT must lie inside ISTAT_W");
      end
   endgenerate

   logic fire;
   logic taken;
   logic halted;

   assign instr_ready = !halted;
   assign fire        = instr_valid && instr_ready;
   assign int_n       = !halted;

   xfer_cond_eval #(
      .PHASE_W  (PHASE_W),
      .DATA_W   (DATA_W),
      .HAS_MASK (HAS_MASK)
   ) u_cond (
      .use_carry (instr_use_carry),
      .cmp_phase (instr_cmp_phase),
      .cmp_data  (instr_cmp_data),
      .polarity  (instr_polarity),
      .exp_phase (instr_phase),
      .cmp_word  (instr_cmp_word),
      .bus_phase (bus_phase),
      .bus_data  (bus_data),
      .alu_carry (alu_carry),
      .cond_true (taken)
   );

   xfer_ip_ctl #(
      .ADDR_W   (ADDR_W),
      .RESET_IP (RESET_IP)
   ) u_ip (
      .clk           (clk),
      .rst_n         (rst_n),
      .fire          (fire),
      .taken         (taken),
      .op            (instr_op),
      .target        (instr_target),
      .host_ip_wr    (host_ip_wr),
      .host_ip_wdata (host_ip_wdata),
      .ip            (ip),
      .ret_addr      (ret_addr)
   );

   xfer_int_ctl #(
      .ADDR_W  (ADDR_W),
      .ISTAT_W (ISTAT_W),
      .FLY_BIT (FLY_BIT)
   ) u_int (
      .clk              (clk),
      .rst_n            (rst_n),
      .fire             (fire),
      .taken            (taken),
      .op               (instr_op),
      .target           (instr_target),
      .host_ip_wr       (host_ip_wr),
      .host_istat_wr    (host_istat_wr),
      .host_istat_wdata (host_istat_wdata),
      .halted           (halted),
      .status_vec       (status_vec),
      .istat            (istat)
   );

   assert_halted_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_n && !host_ip_wr) |=> ($stable(ip) && $stable(ret_addr) && $stable(istat)));

   assert_reserved_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_ready && instr_op > 3'd4 && !host_ip_wr && !host_istat_wr) |=>
         ($stable(ip) && $stable(ret_addr) && int_n && $stable(istat)));

endmodule

// File: tb/xfer_ctl_unit_bench.sv
module xfer_ctl_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic        instr_ready;
   logic [2:0]  instr_op = '0;
   logic        instr_use_carry = 1'b0;
   logic        instr_cmp_phase = 1'b0;
   logic        instr_cmp_data = 1'b0;
   logic        instr_polarity = 1'b1;
   logic [2:0]  instr_phase = '0;
   logic [15:0] instr_cmp_word = '0;
   logic [31:0] instr_target = '0;
   logic [2:0]  bus_phase = '0;
   logic [7:0]  bus_data = '0;
   logic        alu_carry = 1'b0;
   logic        host_ip_wr = 1'b0;
   logic [31:0] host_ip_wdata = '0;
   logic        host_istat_wr = 1'b0;
   logic [7:0]  host_istat_wdata = '0;
   logic [31:0] ip;
   logic [31:0] ret_addr;
   logic        int_n;
   logic [31:0] status_vec;
   logic [7:0]  istat;

   int n_run = 0;
   int n_fail = 0;

   logic [31:0] m_ip = '0;
   logic [31:0] m_ret = '0;
   logic        m_halt = 1'b0;
   logic [31:0] m_vec = '0;
   logic        m_fly = 1'b0;

   always #2.5 clk = ~clk;

   xfer_ctl_unit u_xfer_ctl_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
      .instr_op(instr_op), .instr_use_carry(instr_use_carry),
      .instr_cmp_phase(instr_cmp_phase), .instr_cmp_data(instr_cmp_data),
      .instr_polarity(instr_polarity), .instr_phase(instr_phase),
      .instr_cmp_word(instr_cmp_word), .instr_target(instr_target),
      .bus_phase(bus_phase), .bus_data(bus_data), .alu_carry(alu_carry),
      .host_ip_wr(host_ip_wr), .host_ip_wdata(host_ip_wdata),
      .host_istat_wr(host_istat_wr), .host_istat_wdata(host_istat_wdata),
      .ip(ip), .ret_addr(ret_addr), .int_n(int_n), .status_vec(status_vec), .istat(istat)
   );

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      #1000000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      summary();
      $finish;
   end

   task automatic chk(input string tag);
      logic [7:0] e_istat;
      e_istat = {5'b0, m_fly, 2'b0};
      n_run++;
      if (ip !== m_ip || ret_addr !== m_ret || int_n !== !m_halt ||
          instr_ready !== !m_halt || status_vec !== m_vec || istat !== e_istat) begin
         n_fail++;
         $display("FAIL %s: actual ip=%h ret=%h int_n=%b rdy=%b vec=%h istat=%h expected ip=%h ret=%h int_n=%b rdy=%b vec=%h istat=%h",
                  tag, ip, ret_addr, int_n, instr_ready, status_vec, istat,
                  m_ip, m_ret, !m_halt, !m_halt, m_vec, e_istat);
      end
   endtask

   function automatic bit m_cond();
      bit r;
      if (instr_use_carry) begin
         r = alu_carry;
      end else begin
         r = (!instr_cmp_phase || instr_phase == bus_phase) &&
             (!instr_cmp_data ||
              (((bus_data ^ instr_cmp_word[7:0]) & ~instr_cmp_word[15:8]) == 8'h00));
      end
      return r == instr_polarity;
   endfunction

   // Issue the instruction currently on the bench's drive signals for one cycle.
   task automatic issue(input string tag);
      bit go;
      go = !m_halt && m_cond();
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      if (go) begin
         case (instr_op)
            3'd0: m_ip = instr_target;
            3'd1: begin m_ret = m_ip; m_ip = instr_target; end
            3'd2: m_ip = m_ret;
            3'd3: begin m_halt = 1'b1; m_vec = instr_target; end
            3'd4: m_fly = 1'b1;
            default: ;
         endcase
      end
      chk(tag);
   endtask

   task automatic host_ip(input logic [31:0] v, input string tag);
      host_ip_wr = 1'b1;
      host_ip_wdata = v;
      @(negedge clk);
      host_ip_wr = 1'b0;
      m_ip = v;
      m_halt = 1'b0;
      chk(tag);
   endtask

   task automatic host_istat(input logic [7:0] v, input string tag);
      host_istat_wr = 1'b1;
      host_istat_wdata = v;
      @(negedge clk);
      host_istat_wr = 1'b0;
      if (v[2]) m_fly = 1'b0;
      chk(tag);
   endtask

   task automatic set_carry_cond(input bit cy, input bit pol);
      instr_use_carry = 1'b1;
      instr_cmp_phase = 1'b0;
      instr_cmp_data = 1'b0;
      alu_carry = cy;
      instr_polarity = pol;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release");

      // R8: return before any call takes the reset return value
      host_ip(32'h0000_0100, "R10 host write");
      instr_op = 3'd2;
      instr_target = 32'hDEAD_0000;
      set_carry_cond(1'b1, 1'b1);
      issue("R8 return without call");

      // R2: carry mode, enables ignored
      for (int k = 0; k < 8; k++) begin
         instr_op = 3'd0;
         instr_target = 32'h1000 + k;
         set_carry_cond(k[0], k[1]);
         instr_cmp_phase = k[2];
         instr_phase = 3'd5;
         bus_phase = 3'd2;
         issue("R2 carry test");
      end

      // R3 / R6: exhaustive phase compare with jump
      for (int e = 0; e < 8; e++) begin
         for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 2; p++) begin
               instr_op = 3'd0;
               instr_use_carry = 1'b0;
               instr_cmp_phase = 1'b1;
               instr_cmp_data = 1'b0;
               instr_polarity = p[0];
               instr_phase = e[2:0];
               bus_phase = b[2:0];
               instr_target = 32'h2000 + 32'(e * 16 + b * 2 + p);
               issue("R3 R6 phase jump");
            end
         end
      end

      // R4: masked data compare, ANDed with phase
      for (int d = 0; d < 256; d += 17) begin
         for (int m = 0; m < 4; m++) begin
            for (int pm = 0; pm < 2; pm++) begin
               instr_op = 3'd0;
               instr_use_carry = 1'b0;
               instr_cmp_phase = 1'b1;
               instr_cmp_data = 1'b1;
               instr_polarity = 1'b1;
               instr_phase = 3'd3;
               bus_phase = pm[0] ? 3'd3 : 3'd6;
               instr_cmp_word = {(m == 0) ? 8'h00 : (m == 1) ? 8'h0F : (m == 2) ? 8'hF0 : 8'hFF,
                                 8'hA5};
               bus_data = d[7:0];
               instr_target = 32'h3000 + 32'(d * 8 + m * 2 + pm);
               issue("R4 data compare");
            end
         end
      end
      instr_cmp_phase = 1'b0;
      instr_cmp_data = 1'b1;
      instr_cmp_word = 16'h00A5;
      bus_data = 8'hA5;
      instr_target = 32'h3F00;
      issue("R4 data only exact match");

      // R7 call then R8 return
      host_ip(32'h0000_4444, "R10 host write");
      instr_op = 3'd1;
      instr_target = 32'h5000;
      set_carry_cond(1'b0, 1'b0);
      issue("R7 call");
      instr_op = 3'd0;
      instr_target = 32'h5100;
      issue("R6 jump keeps ret");
      instr_op = 3'd2;
      issue("R8 return");

      // R5: false condition for every opcode
      for (int o = 0; o < 5; o++) begin
         instr_op = o[2:0];
         instr_target = 32'h6000 + o;
         set_carry_cond(1'b1, 1'b0);
         issue("R5 false condition");
      end

      // R12: reserved opcodes with true condition
      for (int o = 5; o < 8; o++) begin
         instr_op = o[2:0];
         instr_target = 32'h7000 + o;
         set_carry_cond(1'b1, 1'b1);
         issue("R12 reserved opcode");
      end

      // R9: halting interrupt, instructions ignored while halted
      instr_op = 3'd3;
      instr_target = 32'hCAFE_0042;
      set_carry_cond(1'b1, 1'b1);
      issue("R9 interrupt halts");
      for (int o = 0; o < 5; o++) begin
         instr_op = o[2:0];
         instr_target = 32'h8000 + o;
         issue("R9 ignored while halted");
      end
      host_ip(32'h0000_9000, "R10 restart");
      instr_op = 3'd0;
      instr_target = 32'h9100;
      issue("R10 runs after restart");

      // R11: on-the-fly flag
      instr_op = 3'd4;
      instr_target = 32'hA000;
      issue("R11 fly sets");
      issue("R11 fly again");
      host_istat(8'hFB, "R11 clear without bit2");
      instr_op = 3'd0;
      instr_target = 32'hA100;
      issue("R11 flag survives jump");
      host_istat(8'h04, "R11 clear bit2");
      host_istat(8'h04, "R11 clear when clear");

      summary();
      $finish;
   end

endmodule